// File: doc/BRIEF.md
# Adaptive Inter-Packet Delay Controller

This block decides how long a frame transmitter must wait between data frames. A transmitter that sends as fast as it can often loses throughput: acknowledgements come back late, and packets get sent a second time before their acknowledgement arrives. The block therefore adjusts the gap in a closed loop. It watches how many of the granted sends were repeats of packets that had already gone out once. When repeats are frequent it makes the gap longer. When there are none it makes the gap shorter.

The packet selector raises `tx_req` when it has a frame ready. It also drives `tx_is_retry` high if the chosen packet already had its sent flag set. The send may happen only in a cycle where `tx_grant` is high. A grant loads a countdown with the current gap, and no further grant is given until that countdown reaches zero. Every `WINDOW` granted sends, the block compares the number of repeats with the number of sends and moves the gap by one step, kept within a minimum and a maximum. The frame formatter copies `gap_cycles` into the header of each data frame.

Top module: `ipg_tuner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `gap_cycles` equals `DELAY_INIT`, `gap_idle` is 1, and both the send count and the repeat count are zero.
- R2: `tx_grant` is 1 exactly in the cycles where `tx_req` is 1 and the countdown is zero (`gap_idle` = 1).
- R3: A grant loads the countdown with the value `gap_cycles` had in that cycle. The countdown then falls by one each cycle until it reaches zero. As a result, two grants are separated by at least `gap_cycles` cycles in which no grant is possible, and a gap of 0 allows back-to-back grants.
- R4: Evaluation happens on the grant that completes `WINDOW` granted sends, and that grant's own repeat flag is counted. After the evaluation both counts restart from zero.
- R5: At evaluation, if repeats × 2^`RATIO_SHIFT` is greater than `WINDOW`, the gap grows by `DELAY_STEP`, and is held at `DELAY_MAX` if it would go past it.
- R6: At evaluation, if the repeat count is zero, the gap shrinks by `DELAY_STEP`, and is held at `DELAY_MIN` if it would go below it.
- R7: At evaluation, if neither R5 nor R6 applies, the gap is unchanged. This includes a repeat fraction of exactly 1/2^`RATIO_SHIFT`.
- R8: `gap_cycles` changes only in the cycle after an evaluation, and it always stays between `DELAY_MIN` and `DELAY_MAX`.
- R9: `tx_is_retry` is ignored in cycles with no grant, so it has no effect on any later evaluation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Selector has a frame ready to send |
| tx_is_retry | input | 1 | Chosen frame had already been sent once |
| tx_grant | output | 1 | Send permitted in this cycle |
| gap_cycles | output | DELAY_W | Current inter-packet delay in clock cycles |
| gap_idle | output | 1 | Countdown is at zero |

## Verification
The bench sets the repeat count exactly on both sides of the threshold. At 16 repeats in 256 sends the gap must stay the same; a design that uses greater-or-equal instead of greater-than would raise it. At 17 repeats the gap must rise. The bench also drives the gap into both limits: a design without saturation would wrap around or pass the configured maximum or minimum. It also holds the repeat flag high on cycles with no grant while other windows contain no repeats; a design that counted that flag would fail to shrink the gap. Finally, the bench compares grants cycle by cycle with a reference model. This catches a countdown that is off by one, or one that loads the gap value after it has already been updated.

// File: rtl/ipg_tuner.sv
module ipg_tuner #(
  parameter int DELAY_W     = 16,
  parameter int DELAY_INIT  = 64,
  parameter int DELAY_MIN   = 0,
  parameter int DELAY_MAX   = 4096,
  parameter int DELAY_STEP  = 1,
  parameter int WINDOW      = 256,
  parameter int RATIO_SHIFT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_req,
  input  logic               tx_is_retry,
  output logic               tx_grant,
  output logic [DELAY_W-1:0] gap_cycles,
  output logic               gap_idle
);

  localparam int CW = $clog2(WINDOW + 1);
  localparam int SW = CW + RATIO_SHIFT + 1;
  localparam int EW = DELAY_W + 1;

  logic [DELAY_W-1:0] delay_q, timer_q;
  logic [CW-1:0]      sent_q, retr_q;

  logic [CW-1:0] retr_nx;
  logic [SW-1:0] retr_scaled;
  logic [EW-1:0] delay_up, delay_dn;
  logic          win_last, too_many, none;

  assign gap_idle   = (timer_q == '0);
  assign tx_grant   = tx_req && gap_idle;
  assign gap_cycles = delay_q;

  assign retr_nx     = retr_q + CW'(tx_is_retry);
  assign retr_scaled = SW'(retr_nx) << RATIO_SHIFT;
  assign win_last    = (sent_q == CW'(WINDOW - 1));
  assign too_many    = retr_scaled > SW'(WINDOW);
  assign none        = (retr_nx == '0);

  assign delay_up = ({1'b0, delay_q} + EW'(DELAY_STEP) > EW'(DELAY_MAX))
                    ? EW'(DELAY_MAX) : {1'b0, delay_q} + EW'(DELAY_STEP);
  assign delay_dn = ({1'b0, delay_q} < EW'(DELAY_MIN + DELAY_STEP))
                    ? EW'(DELAY_MIN) : {1'b0, delay_q} - EW'(DELAY_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q <= '0;
    end else if (tx_grant) begin
      timer_q <= delay_q;
    end else if (!gap_idle) begin
      timer_q <= timer_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q  <= '0;
      retr_q  <= '0;
      delay_q <= DELAY_W'(DELAY_INIT);
    end else if (tx_grant) begin
      if (win_last) begin
        sent_q <= '0;
        retr_q <= '0;
        if (too_many)  delay_q <= delay_up[DELAY_W-1:0];
        else if (none) delay_q <= delay_dn[DELAY_W-1:0];
      end else begin
        sent_q <= sent_q + 1'b1;
        retr_q <= retr_nx;
      end
    end
  end

  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> timer_q == $past(delay_q));

  a_r3_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_grant && timer_q != '0) |=> timer_q == $past(timer_q) - 1'b1);

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant && win_last) |=> (sent_q == '0 && retr_q == '0));

  a_r5_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant && win_last && too_many) |=> gap_cycles >= $past(gap_cycles));

  a_r6_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_grant && win_last && none) |=> gap_cycles <= $past(gap_cycles));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_grant && win_last) |=> $stable(gap_cycles));

  a_r8_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(gap_cycles) >= DELAY_MIN) && (32'(gap_cycles) <= DELAY_MAX));

endmodule

// File: tb/ipg_tuner_tb.sv
module ipg_tuner_tb;
  localparam int DW = 16, INIT = 4, DMIN = 1, DMAX = 8, STEP = 2, WIN = 256;

  logic clk = 0, rst_n = 0, tx_req = 0, tx_is_retry = 0;
  logic tx_grant, gap_idle;
  logic [DW-1:0] gap_cycles;

  ipg_tuner #(.DELAY_W(DW), .DELAY_INIT(INIT), .DELAY_MIN(DMIN), .DELAY_MAX(DMAX),
              .DELAY_STEP(STEP), .WINDOW(WIN), .RATIO_SHIFT(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_is_retry(tx_is_retry),
    .tx_grant(tx_grant), .gap_cycles(gap_cycles), .gap_idle(gap_idle));

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  int m_delay = INIT, m_timer = 0, m_sent = 0, m_retr = 0, m_windows = 0;
  int exp_after[12] = '{6, 8, 8, 6, 4, 2, 1, 1, 1, 3, 3, 1};
  string tag_after[12] = '{"R5", "R5", "R5 sat", "R6", "R6", "R6", "R6 sat",
                           "R6 sat", "R7", "R5", "R7", "R6"};

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic bit retry_for(input int w, input int i);
    case (w)
      0, 1, 2: return 1'b1;
      8:       return i < 16;
      9:       return i < 17;
      10:      return i == 100;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_delay = INIT; m_timer = 0; m_sent = 0; m_retr = 0;
    end else if (tx_req && m_timer == 0) begin
      m_timer = m_delay;
      m_sent++;
      if (tx_is_retry) m_retr++;
      if (m_sent == WIN) begin
        if (m_retr * 16 > WIN) m_delay = (m_delay + STEP > DMAX) ? DMAX : m_delay + STEP;
        else if (m_retr == 0)  m_delay = (m_delay - STEP < DMIN) ? DMIN : m_delay - STEP;
        m_sent = 0; m_retr = 0; m_windows++;
      end
    end else if (m_timer > 0) begin
      m_timer--;
    end
  end

  initial begin
    int seen = 0;
    bit exp_grant;
    repeat (3) @(negedge clk);
    #1;
    check("R1 gap", int'(gap_cycles), INIT);
    check("R1 idle", int'(gap_idle), 1);
    @(negedge clk);
    rst_n = 1;
    while (m_windows < 12) begin
      @(negedge clk);
      if (m_windows != seen) begin
        check({tag_after[seen], " window-end gap"}, int'(gap_cycles), exp_after[seen]);
        seen = m_windows;
      end
      if (m_windows >= 12) break;
      tx_req = (cyc % 11) != 5;
      exp_grant = tx_req && m_timer == 0;
      // R9: flag held high whenever no grant is expected
      tx_is_retry = exp_grant ? retry_for(m_windows, m_sent) : 1'b1;
      #1;
      check("R2 grant", int'(tx_grant), int'(exp_grant));
      check("R3 idle", int'(gap_idle), int'(m_timer == 0));
      check("R8 gap", int'(gap_cycles), m_delay);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule